// File: doc/BRIEF.md
# PWM Shadow Register Update Controller

This block sits between a host write port and a PWM waveform stage. It holds four compare values: the start and end points of output A and the start and end points of output B. It also holds a small output-enable configuration. The host writes each value into a shadow register. The value is copied into the active register that the waveform logic reads only at a safe moment. An external ramp counter supplies a one-cycle end-of-cycle strobe, and every copy is aligned to that strobe. As a result, the active values never change in the middle of a PWM period.

Two control bits govern copying. A manual lock holds all pending values back. An automatic lock copies them at the end of a period, but only when the B-end compare register was the last compare register written. The automatic lock overrides the manual lock.

The same control register carries four more fields:
- a 2-bit ramp mode, exposed as a registered output;
- an output polarity bit;
- an output-override bit that passes the raw waveform through uninverted;
- a clock-source select that picks between a fast and a slow clock-enable input.

The block also drives the two PWM pins from the raw waveform bits, applying polarity, override and output enable. It raises a one-cycle pulse each time the active registers are updated.

Top module: `pwm_shadow_ctrl`

## Requirements
- R1: While the manual lock (control bit 5) is set and the automatic lock (control bit 6) is clear, host writes change only the shadow copies. The active values stay unchanged across end-of-cycle strobes, and no commit pulse occurs.
- R2: With both lock bits clear, pending shadow writes are committed on the clock edge that samples the end-of-cycle strobe. The active values never change on an edge without the strobe.
- R3: After the manual lock is cleared, the values written while it was set are committed at the next end-of-cycle strobe, not at the moment of release.
- R4: With the automatic lock set, a strobe commits only if the most recent compare write targeted B-end (select 3). A later write to select 0, 1 or 2 cancels the commit until B-end is written again.
- R5: When both lock bits are set, the automatic-lock rule applies and the manual lock is ignored.
- R6: `commit_pulse` is high for exactly the cycle after each commit edge. After a commit, a further strobe with no new write produces no commit.
- R7: If a shadow write and the strobe are sampled on the same edge, the active register takes the shadow contents from before that write. The new value stays pending for the next strobe.
- R8: `ramp_mode` reflects control bits 4:3 one cycle after the control write: 00 one-ramp, 01 two-ramp, 10 four-ramp, 11 center-aligned. All control bits reset to zero.
- R9: With the override clear, an enabled output is registered one cycle after its waveform bit. It is the inverse of that bit when polarity (control bit 2) is 0 (active low) and equal to it when polarity is 1 (active high).
- R10: With the override (control bit 1) set, an enabled output equals its waveform bit one cycle later, whatever the polarity.
- R11: `clk_en` is registered from `fast_en` when clock select (control bit 0) is 1, and from `slow_en` when it is 0.
- R12: Select 4 writes the shadowed output enables (data bit 0 for A, bit 1 for B), committed with the compares. A disabled output sits at its inactive level: 1 when polarity is 0, 0 when polarity is 1, and 0 under override. Selects 5 to 7 are ignored.
- R13: After reset, the active compares and enables are zero, `commit_pulse` is 0, `ramp_mode` is 00, and both PWM outputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Shadow write strobe |
| wr_sel | input | 3 | Shadow target: 0 A-start, 1 A-end, 2 B-start, 3 B-end, 4 output enables |
| wr_data | input | DW | Shadow write data |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 7 | Control data: 6 auto lock, 5 lock, 4:3 mode, 2 polarity, 1 override, 0 clock select |
| cycle_end | input | 1 | End-of-cycle strobe from the ramp counter |
| fast_en | input | 1 | Fast clock enable |
| slow_en | input | 1 | Slow clock enable |
| wave_a | input | 1 | Raw waveform bit for output A (1 = active) |
| wave_b | input | 1 | Raw waveform bit for output B (1 = active) |
| cmp_a_start | output | DW | Active A-start compare |
| cmp_a_end | output | DW | Active A-end compare |
| cmp_b_start | output | DW | Active B-start compare |
| cmp_b_end | output | DW | Active B-end compare |
| out_en | output | 2 | Active output enables (bit 0 A, bit 1 B) |
| ramp_mode | output | 2 | Registered ramp mode |
| clk_en | output | 1 | Selected clock enable, registered |
| pwm_a | output | 1 | Output pin A |
| pwm_b | output | 1 | Output pin B |
| commit_pulse | output | 1 | High the cycle after an active-register update |

## Verification
A host write to a shadow register and an end-of-cycle commit can land on the same clock edge. The block must then copy the old shadow contents and keep the new write pending. The random phase drives writes and strobes independently with high probability, so these collisions occur many times under every lock setting. A directed case forces one collision with known values. A reference model built from the requirements judges each collision cycle by cycle, both at the edge itself and at the following strobe.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;

  typedef enum logic [1:0] {
    MODE_ONE_RAMP  = 2'b00,
    MODE_TWO_RAMP  = 2'b01,
    MODE_FOUR_RAMP = 2'b10,
    MODE_CENTER    = 2'b11
  } ramp_mode_e;

  typedef enum logic [2:0] {
    SEL_A_START = 3'd0,
    SEL_A_END   = 3'd1,
    SEL_B_START = 3'd2,
    SEL_B_END   = 3'd3,
    SEL_OUT_CFG = 3'd4
  } wr_sel_e;

  // packed MSB first: bit 6 auto lock ... bit 0 clock select
  typedef struct packed {
    logic       auto_lock;
    logic       lock;
    ramp_mode_e mode;
    logic       pol;
    logic       mtx_en;
    logic       clk_sel;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

endpackage

// File: rtl/pwm_shadow_commit.sv
module pwm_shadow_commit (
  input  logic clk,
  input  logic rst,
  input  logic cmp_wr,
  input  logic bend_wr,
  input  logic any_wr,
  input  logic cycle_end,
  input  logic lock,
  input  logic auto_lock,
  output logic commit,
  output logic commit_pulse
);

  logic pend_q;
  logic lastb_q;

  // automatic lock outranks the manual lock
  always_comb begin
    if (auto_lock) commit = cycle_end && lastb_q;
    else           commit = cycle_end && !lock && pend_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q       <= 1'b0;
      lastb_q      <= 1'b0;
      commit_pulse <= 1'b0;
    end else begin
      commit_pulse <= commit;
      if (any_wr)      pend_q <= 1'b1;
      else if (commit) pend_q <= 1'b0;
      if (cmp_wr)      lastb_q <= bend_wr;
      else if (commit) lastb_q <= 1'b0;
    end
  end

endmodule

// File: rtl/pwm_shadow_bank.sv
module pwm_shadow_bank #(
  parameter int DW   = 16,
  parameter int NCMP = 4,
  parameter int NCFG = 2,
  parameter int SELW = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [SELW-1:0]           wr_sel,
  input  logic [DW-1:0]             wr_data,
  input  logic                      commit,
  output logic [NCMP-1:0][DW-1:0]   act_o,
  output logic [NCFG-1:0]           cfg_o
);

  localparam logic [SELW-1:0] CFG_SEL = SELW'(NCMP);

  genvar g;
  generate
    for (g = 0; g < NCMP; g++) begin : g_cmp
      logic [DW-1:0] sh_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          sh_q     <= '0;
          act_o[g] <= '0;
        end else begin
          if (wr_en && wr_sel == SELW'(g)) sh_q <= wr_data;
          if (commit) act_o[g] <= sh_q;
        end
      end
    end
  endgenerate

  logic [NCFG-1:0] sh_cfg_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_cfg_q <= '0;
      cfg_o    <= '0;
    end else begin
      if (wr_en && wr_sel == CFG_SEL) sh_cfg_q <= wr_data[NCFG-1:0];
      if (commit) cfg_o <= sh_cfg_q;
    end
  end

endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage #(
  parameter int NOUT = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NOUT-1:0] wave,
  input  logic [NOUT-1:0] en,
  input  logic            pol,
  input  logic            mtx_en,
  output logic [NOUT-1:0] pin
);

  genvar g;
  generate
    for (g = 0; g < NOUT; g++) begin : g_out
      logic lvl;
      assign lvl = en[g] & wave[g];
      always_ff @(posedge clk) begin
        if (rst)         pin[g] <= 1'b1;
        else if (mtx_en) pin[g] <= lvl;
        else if (pol)    pin[g] <= lvl;
        else             pin[g] <= ~lvl;
      end
    end
  endgenerate

endmodule

// File: rtl/pwm_shadow_ctrl.sv
module pwm_shadow_ctrl
  import pwm_shadow_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          ctl_we,
  input  logic [6:0]    ctl_wdata,
  input  logic          cycle_end,
  input  logic          fast_en,
  input  logic          slow_en,
  input  logic          wave_a,
  input  logic          wave_b,
  output logic [DW-1:0] cmp_a_start,
  output logic [DW-1:0] cmp_a_end,
  output logic [DW-1:0] cmp_b_start,
  output logic [DW-1:0] cmp_b_end,
  output logic [1:0]    out_en,
  output logic [1:0]    ramp_mode,
  output logic          clk_en,
  output logic          pwm_a,
  output logic          pwm_b,
  output logic          commit_pulse
);

  localparam int NCMP = 4;
  localparam int NOUT = 2;
  localparam int SELW = 3;

  ctl_t ctl_q;
  logic lock_q, auto_q, pol_q, mtx_q, clksel_q;

  always_ff @(posedge clk) begin
    if (rst)         ctl_q <= '0;
    else if (ctl_we) ctl_q <= ctl_t'(ctl_wdata);
  end

  assign lock_q    = ctl_q.lock;
  assign auto_q    = ctl_q.auto_lock;
  assign pol_q     = ctl_q.pol;
  assign mtx_q     = ctl_q.mtx_en;
  assign clksel_q  = ctl_q.clk_sel;
  assign ramp_mode = ctl_q.mode;

  always_ff @(posedge clk) begin
    if (rst) clk_en <= 1'b0;
    else     clk_en <= clksel_q ? fast_en : slow_en;
  end

  logic cmp_wr, bend_wr, any_wr, commit;
  assign cmp_wr  = wr_en && (wr_sel < SELW'(NCMP));
  assign bend_wr = wr_en && (wr_sel == SEL_B_END);
  assign any_wr  = cmp_wr || (wr_en && wr_sel == SEL_OUT_CFG);

  pwm_shadow_commit u_commit (
    .clk          (clk),
    .rst          (rst),
    .cmp_wr       (cmp_wr),
    .bend_wr      (bend_wr),
    .any_wr       (any_wr),
    .cycle_end    (cycle_end),
    .lock         (lock_q),
    .auto_lock    (auto_q),
    .commit       (commit),
    .commit_pulse (commit_pulse)
  );

  logic [NCMP-1:0][DW-1:0] act;

  pwm_shadow_bank #(.DW(DW), .NCMP(NCMP), .NCFG(NOUT), .SELW(SELW)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .commit  (commit),
    .act_o   (act),
    .cfg_o   (out_en)
  );

  assign cmp_a_start = act[SEL_A_START];
  assign cmp_a_end   = act[SEL_A_END];
  assign cmp_b_start = act[SEL_B_START];
  assign cmp_b_end   = act[SEL_B_END];

  logic [NOUT-1:0] pins;

  pwm_out_stage #(.NOUT(NOUT)) u_out (
    .clk    (clk),
    .rst    (rst),
    .wave   ({wave_b, wave_a}),
    .en     (out_en),
    .pol    (pol_q),
    .mtx_en (mtx_q),
    .pin    (pins)
  );

  assign pwm_a = pins[0];
  assign pwm_b = pins[1];

endmodule

// File: rtl/pwm_shadow_chk.sv
module pwm_shadow_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          cycle_end,
  input logic [DW-1:0] cmp_a_start,
  input logic [DW-1:0] cmp_b_end,
  input logic [1:0]    out_en,
  input logic          pol_q,
  input logic          mtx_q,
  input logic          clksel_q,
  input logic          fast_en,
  input logic          slow_en,
  input logic          wave_a,
  input logic          pwm_a,
  input logic          pwm_b,
  input logic          clk_en
);

  a_r2_active_stable: assert property (@(posedge clk) disable iff (rst)
    !cycle_end |=> ($stable(cmp_a_start) && $stable(cmp_b_end) && $stable(out_en)));

  a_r9_active_low: assert property (@(posedge clk) disable iff (rst)
    (!mtx_q && !pol_q && out_en[0]) |=> (pwm_a == !$past(wave_a)));

  a_r10_override: assert property (@(posedge clk) disable iff (rst)
    (mtx_q && out_en[0]) |=> (pwm_a == $past(wave_a)));

  a_r12_idle_level: assert property (@(posedge clk) disable iff (rst)
    (!mtx_q && !out_en[1]) |=> (pwm_b == !$past(pol_q)));

  a_r11_clk_pick: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (clk_en == ($past(clksel_q) ? $past(fast_en) : $past(slow_en))));

endmodule

module pwm_commit_chk (
  input logic clk,
  input logic rst,
  input logic cycle_end,
  input logic lock,
  input logic auto_lock,
  input logic lastb_q,
  input logic commit_pulse
);

  a_r1_lock_blocks: assert property (@(posedge clk) disable iff (rst)
    (lock && !auto_lock && cycle_end) |=> !commit_pulse);

  a_r4_needs_bend: assert property (@(posedge clk) disable iff (rst)
    (auto_lock && cycle_end && !lastb_q) |=> !commit_pulse);

  a_r5_auto_wins: assert property (@(posedge clk) disable iff (rst)
    (auto_lock && lock && cycle_end && lastb_q) |=> commit_pulse);

  a_r6_pulse_on_strobe: assert property (@(posedge clk) disable iff (rst)
    !cycle_end |=> !commit_pulse);

endmodule

bind pwm_shadow_ctrl pwm_shadow_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cycle_end(cycle_end),
  .cmp_a_start(cmp_a_start), .cmp_b_end(cmp_b_end), .out_en(out_en),
  .pol_q(pol_q), .mtx_q(mtx_q), .clksel_q(clksel_q),
  .fast_en(fast_en), .slow_en(slow_en), .wave_a(wave_a),
  .pwm_a(pwm_a), .pwm_b(pwm_b), .clk_en(clk_en)
);

bind pwm_shadow_commit pwm_commit_chk u_cchk (
  .clk(clk), .rst(rst), .cycle_end(cycle_end), .lock(lock),
  .auto_lock(auto_lock), .lastb_q(lastb_q), .commit_pulse(commit_pulse)
);

// File: tb/sim_pwm_shadow_ctrl.sv
`timescale 1ns/1ps
module sim_pwm_shadow_ctrl;

  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_sel = '0;
  logic [DW-1:0] wr_data = '0;
  logic          ctl_we = 1'b0;
  logic [6:0]    ctl_wdata = '0;
  logic          cycle_end = 1'b0;
  logic          fast_en = 1'b0, slow_en = 1'b0, wave_a = 1'b0, wave_b = 1'b0;
  logic [DW-1:0] cmp_a_start, cmp_a_end, cmp_b_start, cmp_b_end;
  logic [1:0]    out_en, ramp_mode;
  logic          clk_en, pwm_a, pwm_b, commit_pulse;

  always #5 clk = ~clk;

  pwm_shadow_ctrl #(.DW(DW)) u0 (.*);

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // reference model, built from the requirements
  logic [DW-1:0] m_sh [4];
  logic [DW-1:0] m_act [4];
  logic [1:0]    m_scfg, m_acfg, m_pwm;
  logic [6:0]    m_ctl;
  logic          m_pend, m_lastb, m_pulse, m_clk;

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 4; k++) begin m_sh[k] = '0; m_act[k] = '0; end
      m_scfg = '0; m_acfg = '0; m_pwm = 2'b11; m_ctl = '0;
      m_pend = 0; m_lastb = 0; m_pulse = 0; m_clk = 0;
    end else begin
      logic cm, isc, iscfg, lvl;
      logic [1:0] wv;
      wv = {wave_b, wave_a};
      cm = cycle_end && (m_ctl[6] ? m_lastb : (!m_ctl[5] && m_pend));
      for (int k = 0; k < 2; k++) begin
        lvl = m_acfg[k] & wv[k];
        m_pwm[k] = m_ctl[1] ? lvl : (m_ctl[2] ? lvl : !lvl);
      end
      m_clk = m_ctl[0] ? fast_en : slow_en;
      if (cm) begin
        for (int k = 0; k < 4; k++) m_act[k] = m_sh[k];
        m_acfg = m_scfg;
      end
      m_pulse = cm;
      isc   = wr_en && (wr_sel < 3'd4);
      iscfg = wr_en && (wr_sel == 3'd4);
      if (isc || iscfg) m_pend = 1; else if (cm) m_pend = 0;
      if (isc) m_lastb = (wr_sel == 3'd3); else if (cm) m_lastb = 0;
      if (isc) m_sh[wr_sel[1:0]] = wr_data;
      if (iscfg) m_scfg = wr_data[1:0];
      if (ctl_we) m_ctl = ctl_wdata;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R1 R2 R4 cmp_a_start", cmp_a_start, m_act[0]);
    chk("R3 R5 cmp_a_end", cmp_a_end, m_act[1]);
    chk("R7 cmp_b_start", cmp_b_start, m_act[2]);
    chk("R4 cmp_b_end", cmp_b_end, m_act[3]);
    chk("R12 out_en", out_en, m_acfg);
    chk("R6 commit_pulse", commit_pulse, m_pulse);
    chk("R8 ramp_mode", ramp_mode, m_ctl[4:3]);
    chk("R11 clk_en", clk_en, m_clk);
    chk("R9 R10 pwm_a", pwm_a, m_pwm[0]);
    chk("R9 R10 pwm_b", pwm_b, m_pwm[1]);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    wr_en = 0; ctl_we = 0; cycle_end = 0;
  endtask

  task automatic wr(input logic [2:0] s, input logic [DW-1:0] d);
    wr_en = 1; wr_sel = s; wr_data = d; tick();
  endtask

  task automatic ctl(input logic [6:0] v);
    ctl_we = 1; ctl_wdata = v; tick();
  endtask

  task automatic strobe();
    cycle_end = 1; tick();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R13 reset state
    chk("R13 cmp_b_end reset", cmp_b_end, 0);
    chk("R13 pulse reset", commit_pulse, 0);
    chk("R13 mode reset", ramp_mode, 0);
    chk("R13 pwm_a reset", pwm_a, 1);
    chk("R13 pwm_b reset", pwm_b, 1);

    // R2 commit only on strobe
    wr(3'd0, 16'h1111);
    tick();
    chk("R2 no mid-cycle update", cmp_a_start, 0);
    strobe();
    chk("R2 commit on strobe", cmp_a_start, 16'h1111);
    chk("R6 pulse after commit", commit_pulse, 1);
    tick();
    chk("R6 pulse one cycle", commit_pulse, 0);
    strobe();
    chk("R6 no repeat commit", commit_pulse, 0);

    // R1 lock holds shadow values
    ctl(7'h20);
    wr(3'd3, 16'hBEEF);
    strobe();
    chk("R1 locked active", cmp_b_end, 0);
    chk("R1 locked no pulse", commit_pulse, 0);

    // R3 release then commit at next strobe
    ctl(7'h00);
    tick();
    chk("R3 no commit at release", cmp_b_end, 0);
    strobe();
    chk("R3 commit after release", cmp_b_end, 16'hBEEF);

    // R4 auto lock
    ctl(7'h40);
    wr(3'd1, 16'h2222);
    strobe();
    chk("R4 no commit without B-end", cmp_a_end, 0);
    wr(3'd3, 16'h3333);
    wr(3'd0, 16'h4444);
    strobe();
    chk("R4 cancelled by later write", cmp_b_end, 16'hBEEF);
    wr(3'd3, 16'h5555);
    strobe();
    chk("R4 commit after B-end last", cmp_b_end, 16'h5555);
    chk("R4 A-end with it", cmp_a_end, 16'h2222);

    // R5 auto wins over lock
    ctl(7'h60);
    wr(3'd2, 16'h6666);
    wr(3'd3, 16'h7777);
    strobe();
    chk("R5 auto overrides lock", cmp_b_start, 16'h6666);

    // R7 write and strobe on one edge
    ctl(7'h00);
    wr(3'd2, 16'h8888);
    wr_en = 1; wr_sel = 3'd2; wr_data = 16'h9999; cycle_end = 1; tick();
    chk("R7 prior shadow committed", cmp_b_start, 16'h8888);
    strobe();
    chk("R7 new value at next strobe", cmp_b_start, 16'h9999);

    // R12 enable outputs, ignored selects
    wr(3'd5, 16'hFFFF);
    wr(3'd7, 16'hFFFF);
    strobe();
    chk("R12 ignored selects", out_en, 0);
    wr(3'd4, 16'h0001);
    strobe();
    chk("R12 enable A only", out_en, 2'b01);

    // R9 polarity, R10 override, R12 idle level
    wave_a = 1; wave_b = 1; tick();
    chk("R9 active low", pwm_a, 0);
    chk("R12 disabled idle high", pwm_b, 1);
    ctl(7'h04);
    tick();
    chk("R9 active high", pwm_a, 1);
    chk("R12 disabled idle low", pwm_b, 0);
    ctl(7'h02);
    wave_a = 0; tick();
    chk("R10 override pass", pwm_a, 0);
    chk("R10 override idle", pwm_b, 0);

    // R8 mode encodings
    for (int m = 0; m < 4; m++) begin
      ctl(7'(m << 3));
      chk("R8 mode field", ramp_mode, m);
    end

    // R11 clock select
    ctl(7'h01);
    fast_en = 1; slow_en = 0; tick();
    chk("R11 fast pick", clk_en, 1);
    ctl(7'h00);
    tick();
    chk("R11 slow pick", clk_en, 0);

    // random phase: writes and strobes collide often (R7)
    for (int i = 0; i < 4000; i++) begin
      wr_en     = ($urandom % 3) != 0;
      wr_sel    = 3'($urandom % 6);
      wr_data   = DW'($urandom);
      cycle_end = ($urandom % 3) == 0;
      ctl_we    = ($urandom % 10) == 0;
      ctl_wdata = 7'($urandom);
      wave_a = 1'($urandom); wave_b = 1'($urandom);
      fast_en = 1'($urandom); slow_en = 1'($urandom);
      tick();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule